// File: doc/BRIEF.md
# Link Round-Trip Delay Timer

This block times a full round trip over an 8B/10B serial link with a resolution of one bit period. The transmit side is handed to the block in character form, two 8-bit characters per word with one control-character flag each. While nothing is being measured, the block fills that word with the idle pair: a K28.5 comma followed by the D16.2 data character. A start command replaces one idle word with a marker word, which is K23.7 followed by a data character. At the same moment the block arms a word-clock counter.

The far end loops the stream back. Once the receive side has been word-aligned, the marker arrives in the first character position of a receive word. The block then stops the counter. It combines the count of word periods with the bit-slip value that the word aligner reports. The result is a total in unit intervals: at 3.125 Gbps with 20 line bits per word, one word period is 6.4 ns and one unit interval is 320 ps. A one-cycle done pulse marks a new result. The result then stays on the output until the next start.

Receive and transmit words are assumed to be on the same word clock. This holds because the receiver is locked to the returning transmitter clock. Serialization, 8B/10B coding and word alignment happen outside the block.

Top module: `ldt_link_timer`

## Requirements
- R1: While rst_n is low at a clock edge, the block drives the idle word on the transmit port after that edge, and holds done, busy and delay_ui at 0.
- R2: With no start pending, every transmit word is the idle word. The first character in time is in tx_data[7:0] and is K28.5 (0xBC, tx_k[0]=1). The second is D16.2 (0x50, tx_k[1]=0), which gives tx_data=0x50BC and tx_k=2'b01.
- R3: A start sampled at a clock edge makes the next transmit word the marker: tx_data[7:0]=0xF7 (K23.7, tx_k[0]=1) and tx_data[15:8]=MARKER_DATA (default 0xAA, tx_k[1]=0). The marker lasts exactly one word, and the idle word follows it.
- R4: If the marker reaches the receive port D word cycles after it left the transmit port, the result is delay_ui = D*WORD_BITS + rx_slip. For D=0, the receive port is the same word as the transmit port.
- R5: done rises in the cycle after the marker is present on the receive port and lasts one cycle. delay_ui keeps its value until the next start.
- R6: busy is high from the cycle after a start until the cycle in which done rises. In that cycle busy is low.
- R7: A marker on the receive port while busy is low is ignored: there is no done pulse and delay_ui does not change.
- R8: A receive word counts as the marker only if rx_data[7:0]=0xF7 with rx_k[0]=1 and rx_k[1]=0. K23.7 in the second position, K23.7 without its control flag, and K23.7 followed by a control character are all ignored.
- R9: A start always re-arms the block, even during a measurement or when a marker arrives at the same edge. From the next cycle delay_ui reads 0, busy is 1 and done is 0, and counting starts again from that start.
- R10: The word count saturates at 2^COUNT_W-1, so a late marker reports (2^COUNT_W-1)*WORD_BITS + rx_slip. The default COUNT_W=18 covers about 1.67 ms, which is well beyond the roughly 490 us of a 100 km loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (156.25 MHz at 3.125 Gbps) |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start command, one cycle |
| rx_data | input | 16 | Aligned receive word, first character in bits 7:0 |
| rx_k | input | 2 | Control-character flags of the receive word |
| rx_slip | input | SLIP_W | Bit-slip value from the word aligner, below WORD_BITS |
| tx_data | output | 16 | Transmit word, first character in bits 7:0 |
| tx_k | output | 2 | Control-character flags of the transmit word |
| delay_ui | output | COUNT_W+SLIP_W | Round-trip delay in unit intervals |
| done | output | 1 | One-cycle pulse when delay_ui is new |
| busy | output | 1 | Measurement armed |

## Verification
A start taken at clock edge N puts the marker on the transmit port right after edge N and brings busy high. Both are checked at the falling edge that follows. A marker that arrives D words later is sampled at edge N+D+1, so the bench polls done at every falling edge and demands the first sighting exactly D+1 falling edges after the start pulse. At that same point it checks delay_ui and busy. For words injected straight into the receive port, a marker placed at falling edge j after the start must give a count of j, with the result visible one falling edge later. Hold, ignore and restart cases are checked at the falling edges where a wrong result would first show.

// File: rtl/ldt_pkg.sv
// Shared character codes for the link delay timer.
// Assumes two 8-bit characters per word, first character in the low byte.
package ldt_pkg;
    typedef logic [7:0] char_t;

    localparam int    CHARS_PER_WORD = 2;
    localparam int    CHAR_BITS      = 8;
    localparam int    WORD_W         = CHARS_PER_WORD * CHAR_BITS;

    localparam char_t CH_COMMA  = 8'hBC;  // K28.5
    localparam char_t CH_IDLE_D = 8'h50;  // D16.2
    localparam char_t CH_MARK_K = 8'hF7;  // K23.7
endpackage

// File: rtl/ldt_tx_inserter.sv
// Transmit word source: idle pairs by default, one marker word after a start.
// Assumes start is a single-cycle command in the word clock domain.
module ldt_tx_inserter
    import ldt_pkg::*;
#(
    parameter char_t MARKER_DATA = 8'hAA
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    output logic [WORD_W-1:0]         tx_data,
    output logic [CHARS_PER_WORD-1:0] tx_k
);
    localparam logic [WORD_W-1:0]         IDLE_WORD = {CH_IDLE_D, CH_COMMA};
    localparam logic [WORD_W-1:0]         MARK_WORD = {MARKER_DATA, CH_MARK_K};
    localparam logic [CHARS_PER_WORD-1:0] LEAD_K    = CHARS_PER_WORD'(1);

    // Register the outgoing word: the marker in place of one idle word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= IDLE_WORD;
            tx_k    <= LEAD_K;
        end else begin
            tx_data <= start ? MARK_WORD : IDLE_WORD;
            tx_k    <= LEAD_K;
        end
    end
endmodule

// File: rtl/ldt_marker_detect.sv
// Recognises the marker word in an already aligned receive stream.
// Assumes the aligner places ordered sets in the first character position.
module ldt_marker_detect
    import ldt_pkg::*;
(
    input  logic [WORD_W-1:0]         rx_data,
    input  logic [CHARS_PER_WORD-1:0] rx_k,
    output logic                      hit
);
    logic lead_is_mark;
    logic tail_is_data;
    logic unused_rx_payload;

    // Decode the lead control character and the data flag of the tail.
    always_comb begin
        lead_is_mark      = rx_k[0] && (rx_data[CHAR_BITS-1:0] == CH_MARK_K);
        tail_is_data      = (rx_k[CHARS_PER_WORD-1:1] == '0);
        hit               = lead_is_mark && tail_is_data;
        unused_rx_payload = ^rx_data[WORD_W-1:CHAR_BITS];
    end
endmodule

// File: rtl/ldt_coarse_counter.sv
// Word-period counter: cleared and armed by start, disarmed by a hit.
// Assumes start has priority over a simultaneous hit; saturates at all ones.
module ldt_coarse_counter #(
    parameter int COUNT_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               hit,
    output logic               armed,
    output logic [COUNT_W-1:0] count
);
    localparam logic [COUNT_W-1:0] COUNT_MAX = {COUNT_W{1'b1}};

    // Arm on start, stop on the first hit while armed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (start)
            armed <= 1'b1;
        else if (hit)
            armed <= 1'b0;
    end

    // Count word periods while armed, holding at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (start)
            count <= '0;
        else if (armed && !hit && count != COUNT_MAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ldt_result_combiner.sv
// Merges word count and bit slip into unit intervals and raises done.
// Assumes slip is below WORD_BITS so the sum never overflows RES_W.
module ldt_result_combiner #(
    parameter int COUNT_W   = 18,
    parameter int WORD_BITS = 20,
    parameter int SLIP_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      stop,
    input  logic [COUNT_W-1:0]        count,
    input  logic [SLIP_W-1:0]         slip,
    output logic [COUNT_W+SLIP_W-1:0] result,
    output logic                      done
);
    localparam int RES_W = COUNT_W + SLIP_W;

    logic [RES_W-1:0] total;

    // Scale the word count to unit intervals and add the slip.
    always_comb begin
        total = RES_W'(count) * RES_W'(WORD_BITS) + RES_W'(slip);
    end

    // Capture the total on stop, clear it on start, pulse done once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else if (start) begin
            result <= '0;
            done   <= 1'b0;
        end else if (stop) begin
            result <= total;
            done   <= 1'b1;
        end else begin
            done   <= 1'b0;
        end
    end
endmodule

// File: rtl/ldt_link_timer.sv
// Round-trip delay timer for an 8B/10B link, top level.
// Assumes transmit and aligned receive words share one word clock and that
// rx_slip is stable when the marker arrives.
module ldt_link_timer
    import ldt_pkg::*;
#(
    parameter int    WORD_BITS   = 20,
    parameter int    COUNT_W     = 18,
    parameter char_t MARKER_DATA = 8'hAA,
    parameter int    SLIP_W      = $clog2(WORD_BITS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [15:0]               rx_data,
    input  logic [1:0]                rx_k,
    input  logic [SLIP_W-1:0]         rx_slip,
    output logic [15:0]               tx_data,
    output logic [1:0]                tx_k,
    output logic [COUNT_W+SLIP_W-1:0] delay_ui,
    output logic                      done,
    output logic                      busy
);
    logic               hit;
    logic               armed;
    logic               stop;
    logic [COUNT_W-1:0] count;

    ldt_tx_inserter #(.MARKER_DATA(MARKER_DATA)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_data (tx_data),
        .tx_k    (tx_k)
    );

    ldt_marker_detect u_det (
        .rx_data (rx_data),
        .rx_k    (rx_k),
        .hit     (hit)
    );

    ldt_coarse_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .hit   (hit),
        .armed (armed),
        .count (count)
    );

    // Only a hit during an armed measurement ends it.
    always_comb begin
        stop = hit && armed;
        busy = armed;
    end

    ldt_result_combiner #(
        .COUNT_W   (COUNT_W),
        .WORD_BITS (WORD_BITS),
        .SLIP_W    (SLIP_W)
    ) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (stop),
        .count  (count),
        .slip   (rx_slip),
        .result (delay_ui),
        .done   (done)
    );
endmodule

// File: rtl/ldt_link_timer_chk.sv
// Temporal checks on the timer's ports, bound to every ldt_link_timer.
module ldt_link_timer_chk #(
    parameter int WORD_BITS = 20,
    parameter int COUNT_W   = 18,
    parameter int SLIP_W    = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic [15:0]               tx_data,
    input logic [1:0]                tx_k,
    input logic [COUNT_W+SLIP_W-1:0] delay_ui,
    input logic                      done,
    input logic                      busy
);
    localparam int RES_W = COUNT_W + SLIP_W;
    localparam logic [RES_W-1:0] RES_LIMIT =
        RES_W'(((2 ** COUNT_W) - 1) * WORD_BITS + WORD_BITS - 1);

    // R3: a marker on the transmit port follows a start one cycle earlier
    p_marker_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_k[0] && tx_data[7:0] == 8'hF7) |-> $past(start));

    // R2: without a start the next word is idle
    p_idle_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (tx_data == 16'h50BC && tx_k == 2'b01));

    // R5: done is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done ends an armed measurement
    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7: an idle block keeps its result
    p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(delay_ui));

    // R9: a start re-arms and clears the result
    p_start_rearms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done && delay_ui == '0));

    // R10: a saturated count bounds the result
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (delay_ui <= RES_LIMIT));
endmodule

bind ldt_link_timer ldt_link_timer_chk #(
    .WORD_BITS (WORD_BITS),
    .COUNT_W   (COUNT_W),
    .SLIP_W    (SLIP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tx_data  (tx_data),
    .tx_k     (tx_k),
    .delay_ui (delay_ui),
    .done     (done),
    .busy     (busy)
);

// File: tb/ldt_link_timer_test.sv
// Directed bench: loopback delay line plus direct receive-word injection.
module ldt_link_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 8;
    localparam int WB         = 20;
    localparam int SW         = 5;
    localparam int RW         = CW + SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   rx_data;
    logic [1:0]    rx_k;
    logic [SW-1:0] rx_slip = '0;
    logic [15:0]   tx_data;
    logic [1:0]    tx_k;
    logic [RW-1:0] delay_ui;
    logic          done;
    logic          busy;

    int            errors = 0;
    int            checks = 0;

    int            loop_d = 0;
    logic          use_inj = 1'b0;
    logic [15:0]   inj_data = 16'h50BC;
    logic [1:0]    inj_k = 2'b01;
    logic [17:0]   pipe [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Loopback delay line fed from the transmit port.
    always_ff @(posedge clk) begin
        pipe[0] <= {tx_k, tx_data};
        for (int i = 1; i < 64; i++) pipe[i] <= pipe[i-1];
    end

    // Receive port: injected word or loopback tap.
    always_comb begin
        if (use_inj)
            {rx_k, rx_data} = {inj_k, inj_data};
        else if (loop_d == 0)
            {rx_k, rx_data} = {tx_k, tx_data};
        else
            {rx_k, rx_data} = pipe[loop_d-1];
    end

    ldt_link_timer #(.WORD_BITS(WB), .COUNT_W(CW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rx_data  (rx_data),
        .rx_k     (rx_k),
        .rx_slip  (rx_slip),
        .tx_data  (tx_data),
        .tx_k     (tx_k),
        .delay_ui (delay_ui),
        .done     (done),
        .busy     (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic rx_idle();
        inj_data = 16'h50BC;
        inj_k    = 2'b01;
    endtask

    task automatic rx_marker();
        inj_data = 16'h00F7;
        inj_k    = 2'b01;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_data == 16'h50BC, "R1 tx_data", int'(tx_data), 16'h50BC);
        chk(tx_k == 2'b01, "R1 tx_k", int'(tx_k), 1);
        chk(!done, "R1 done", int'(done), 0);
        chk(!busy, "R1 busy", int'(busy), 0);
        chk(delay_ui == '0, "R1 delay_ui", int'(delay_ui), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_data == 16'h50BC && tx_k == 2'b01, "R2 idle word", int'(tx_data), 16'h50BC);
    endtask

    task automatic t_measure(input int d, input int slip);
        int  expv;
        bit  early;
        use_inj = 1'b0;
        loop_d  = d;
        rx_slip = SW'(slip);
        expv    = d * WB + slip;
        early   = 1'b0;
        repeat (70) @(negedge clk);
        pulse_start();
        chk(tx_data == 16'hAAF7 && tx_k == 2'b01, "R3 marker word", int'(tx_data), 16'hAAF7);
        chk(busy, "R6 busy after start", int'(busy), 1);
        for (int i = 1; i <= d + 1; i++) begin
            @(negedge clk);
            if (i == 1)
                chk(tx_data == 16'h50BC && tx_k == 2'b01, "R3 one marker word only", int'(tx_data), 16'h50BC);
            if (i <= d && done) early = 1'b1;
        end
        chk(!early, "R5 done not early", int'(early), 0);
        chk(done, "R5 done at D+1", int'(done), 1);
        chk(int'(delay_ui) == expv, "R4 delay_ui", int'(delay_ui), expv);
        chk(!busy, "R6 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(!done, "R5 one-cycle done", int'(done), 0);
        repeat (15) @(negedge clk);
        chk(int'(delay_ui) == expv, "R5 result held", int'(delay_ui), expv);
    endtask

    task automatic t_stray();
        int prev;
        bit seen;
        prev    = int'(delay_ui);
        seen    = 1'b0;
        use_inj = 1'b1;
        rx_idle();
        @(negedge clk) rx_marker();
        @(negedge clk) rx_idle();
        if (done) seen = 1'b1;
        @(negedge clk);
        if (done) seen = 1'b1;
        chk(!seen, "R7 no done when idle", int'(seen), 0);
        chk(int'(delay_ui) == prev, "R7 result unchanged", int'(delay_ui), prev);
        chk(!busy, "R7 stays idle", int'(busy), 0);
    endtask

    task automatic t_lane();
        use_inj = 1'b1;
        rx_slip = SW'(4);
        rx_idle();
        pulse_start();
        repeat (2) @(negedge clk);
        inj_data = 16'hF7BC; inj_k = 2'b11;
        @(negedge clk);
        inj_data = 16'h50F7; inj_k = 2'b00;
        chk(!done, "R8 K23.7 in second position", int'(done), 0);
        @(negedge clk);
        inj_data = 16'hBCF7; inj_k = 2'b11;
        chk(!done, "R8 K23.7 without control flag", int'(done), 0);
        @(negedge clk);
        rx_marker();
        chk(!done, "R8 K23.7 with control tail", int'(done), 0);
        chk(busy, "R8 still armed", int'(busy), 1);
        @(negedge clk);
        rx_idle();
        chk(done, "R8 valid marker stops", int'(done), 1);
        chk(int'(delay_ui) == 5 * WB + 4, "R8 result", int'(delay_ui), 5 * WB + 4);
    endtask

    task automatic t_restart();
        use_inj = 1'b1;
        rx_slip = SW'(2);
        rx_idle();
        pulse_start();
        chk(delay_ui == '0, "R9 start clears result", int'(delay_ui), 0);
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && !done, "R9 re-armed", int'(busy), 1);
        repeat (7) @(negedge clk);
        rx_marker();
        @(negedge clk) rx_idle();
        chk(done, "R9 done after restart", int'(done), 1);
        chk(int'(delay_ui) == 7 * WB + 2, "R9 count from second start", int'(delay_ui), 7 * WB + 2);
        pulse_start();
        repeat (3) @(negedge clk);
        start = 1'b1;
        rx_marker();
        @(negedge clk);
        start = 1'b0;
        rx_idle();
        chk(!done && busy, "R9 start wins over marker", int'(done), 0);
        chk(delay_ui == '0, "R9 cleared on collision", int'(delay_ui), 0);
        repeat (2) @(negedge clk);
        rx_marker();
        @(negedge clk) rx_idle();
        chk(done, "R9 done after collision", int'(done), 1);
        chk(int'(delay_ui) == 2 * WB + 2, "R9 count after collision", int'(delay_ui), 2 * WB + 2);
    endtask

    task automatic t_saturate();
        int expv;
        expv    = ((1 << CW) - 1) * WB + 3;
        use_inj = 1'b1;
        rx_slip = SW'(3);
        rx_idle();
        pulse_start();
        repeat (300) @(negedge clk);
        chk(busy, "R10 armed while counting", int'(busy), 1);
        rx_marker();
        @(negedge clk) rx_idle();
        chk(done, "R10 done after ceiling", int'(done), 1);
        chk(int'(delay_ui) == expv, "R10 saturated result", int'(delay_ui), expv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_measure(0, 0);
        t_measure(5, 7);
        t_measure(37, 19);
        t_stray();
        t_lane();
        t_restart();
        t_saturate();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule